// File: doc/BRIEF.md
# Return-to-Zero FIR DAC Tap Sequencer

This block turns a single-bit sigma-delta bitstream into the drive bits for the switching taps of a uniformly weighted, return-to-zero FIR DAC. Each incoming bit is captured on a bit-rate strobe. A tap shift register then carries it at twice the bit rate, so every bit occupies two neighbouring stages. The taps are split into an even group and an odd group. On every rising edge of the fast clock, one group is driven with its shifted data and the other group is forced to zero. The next edge swaps the two groups.

Because both groups switch on the same edge, the number of active taps always equals the sum of NUM_TAPS/2 consecutive data bits. That sum holds for two fast cycles and then slides by one bit. A timing error on one edge can therefore move the averaged level by at most one bit's worth. A population count of the active tap outputs is provided so that the averaging can be observed at the ports.

Top module: `rtzfir_seq`

## Requirements
- R1: `bitStrobe` is high on every second fast cycle, on edges 1, 3, 5 … counted from the first edge after reset is released. `serIn` is sampled only on a rising edge where `bitStrobe` is high. Its value on all other edges has no effect on the outputs.
- R2: After every rising edge, at least one tap group is all zero. The even group is the taps with even index; the odd group is the taps with odd index.
- R3: The enabled group alternates on every fast edge. The first edge after reset is released drives the even group, and the next edge drives the odd group.
- R4: Number the edges k = 1, 2, … after reset is released, and let b_m be the m-th strobed bit (b_0 is captured on edge 1). After edge k, tap i drives b_floor((k-3-i)/2) when i mod 2 equals (k-1) mod 2, and drives 0 otherwise. Indices below zero read as 0.
- R5: After edge k, `activeCount` equals the sum of the NUM_TAPS/2 consecutive bits ending at b_(m-1), where m = floor((k-1)/2). The same window therefore holds for two consecutive edges, and the next window drops its oldest bit and adds the newest one.
- R6: `activeCount` changes by at most one from one fast cycle to the next.
- R7: A synchronous reset clears every shift stage and every tap output, so `activeCount` reads 0. This also holds when reset is applied in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, running at twice the bit rate; all flops use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitStrobe | input | 1 | Bit-rate qualifier, high on every second fast cycle |
| serIn | input | 1 | Serial sigma-delta data |
| tapOut | output | NUM_TAPS | Registered return-to-zero drive bit for each tap |
| activeCount | output | $clog2(NUM_TAPS+1) | Number of tap outputs currently high |

## Verification
The bench builds two instances side by side from the same stimulus. The first has NUM_TAPS = 16, so each window averages eight bits. The second has NUM_TAPS = 4, where the window is only two bits wide and the pairing of equal levels follows the pattern (D0+D1), (D0+D1), (D1+D2), (D1+D2). The deep register lets the bench check sliding sums over long runs of ones, zeros and alternating bits. The short one exposes any one-edge error in latency or group phase immediately. On the cycles where the strobe is low, the bench drives data that contradicts the stored bit, which shows that those cycles are ignored.

// File: rtl/rtzfir_pkg.sv
package rtzfir_pkg;
  // Strobes from the control to the datapath, valid for the current fast cycle
  typedef struct packed {
    logic loadBit;    // capture serial data on this edge
    logic driveEven;  // enable the even tap group on this edge
  } seqCtrl_t;
endpackage

// File: rtl/rtzfir_ctrl.sv
module rtzfir_ctrl
  import rtzfir_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bitStrobe,
  output seqCtrl_t ctrl
);
  logic phaseOdd;

  // The phase is fixed at reset, so the even group goes first
  always_ff @(posedge clk) begin
    if (rst) phaseOdd <= 1'b0;
    else     phaseOdd <= ~phaseOdd;
  end

  always_comb begin
    ctrl.loadBit   = bitStrobe;
    ctrl.driveEven = ~phaseOdd;
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    bitStrobe |=> !bitStrobe); // R1

  AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    ctrl.driveEven |=> !ctrl.driveEven); // R3
endmodule

// File: rtl/rtzfir_datapath.sv
module rtzfir_datapath
  import rtzfir_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  localparam int CNT_W = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  seqCtrl_t            ctrl,
  input  logic                serIn,
  output logic [NUM_TAPS-1:0] tapOut,
  output logic [CNT_W-1:0]    activeCount
);
  function automatic logic [NUM_TAPS-1:0] parityMask(input logic oddSel);
    logic [NUM_TAPS-1:0] m;
    for (int i = 0; i < NUM_TAPS; i++) m[i] = ((i % 2) == 1) == oddSel;
    return m;
  endfunction

  localparam logic [NUM_TAPS-1:0] EVEN_MASK = parityMask(1'b0);
  localparam logic [NUM_TAPS-1:0] ODD_MASK  = parityMask(1'b1);

  logic                dataHold;
  logic [NUM_TAPS-1:0] stage;
  logic                outOdd;

  // Bit capture: held for two fast cycles between strobes
  always_ff @(posedge clk) begin
    if (rst)               dataHold <= 1'b0;
    else if (ctrl.loadBit) dataHold <= serIn;
  end

  // Tap shift register at twice the bit rate
  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[NUM_TAPS-2:0], dataHold};
  end

  // Registered gating: one group follows its stage, the other returns to zero
  for (genvar i = 0; i < NUM_TAPS; i++) begin : gTap
    if ((i % 2) == 0) begin : gEven
      always_ff @(posedge clk) begin
        if (rst) tapOut[i] <= 1'b0;
        else     tapOut[i] <= ctrl.driveEven & stage[i];
      end
    end else begin : gOdd
      always_ff @(posedge clk) begin
        if (rst) tapOut[i] <= 1'b0;
        else     tapOut[i] <= ~ctrl.driveEven & stage[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outOdd <= 1'b1;
    else     outOdd <= ~ctrl.driveEven;
  end

  always_comb begin
    activeCount = '0;
    for (int i = 0; i < NUM_TAPS; i++) activeCount = activeCount + CNT_W'(tapOut[i]);
  end

  AST_ONE_GROUP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((tapOut & EVEN_MASK) == '0) || ((tapOut & ODD_MASK) == '0)); // R2

  AST_GROUP_SWAP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outOdd != $past(outOdd)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadBit |=> $stable(dataHold)); // R1

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (activeCount <= $past(activeCount) + 1'b1) &&
             ($past(activeCount) <= activeCount + 1'b1)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (tapOut == '0) && (stage == '0)); // R7
endmodule

// File: rtl/rtzfir_seq.sv
module rtzfir_seq
  import rtzfir_pkg::*;
#(
  parameter int NUM_TAPS = 16,
  localparam int CNT_W = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitStrobe,
  input  logic                serIn,
  output logic [NUM_TAPS-1:0] tapOut,
  output logic [CNT_W-1:0]    activeCount
);
  seqCtrl_t ctrl;

  initial begin
    if ((NUM_TAPS < 2) || ((NUM_TAPS % 2) != 0))
      $error("NUM_TAPS must be even and at least 2");
  end

  rtzfir_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .bitStrobe (bitStrobe),
    .ctrl      (ctrl)
  );

  rtzfir_datapath #(.NUM_TAPS(NUM_TAPS)) uDp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .serIn       (serIn),
    .tapOut      (tapOut),
    .activeCount (activeCount)
  );
endmodule

// File: tb/tb_rtzfir_seq.sv
module tb_rtzfir_seq;
  localparam int NB = 96;
  localparam int TAPS_A = 16;
  localparam int TAPS_B = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitStrobe = 1'b0;
  logic serIn = 1'b0;
  logic [TAPS_A-1:0] tapA;
  logic [4:0]        cntA;
  logic [TAPS_B-1:0] tapB;
  logic [2:0]        cntB;

  int bits [NB];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtzfir_seq #(.NUM_TAPS(TAPS_A)) dut (
    .clk(clk), .rst(rst), .bitStrobe(bitStrobe), .serIn(serIn),
    .tapOut(tapA), .activeCount(cntA));

  rtzfir_seq #(.NUM_TAPS(TAPS_B)) dutSmall (
    .clk(clk), .rst(rst), .bitStrobe(bitStrobe), .serIn(serIn),
    .tapOut(tapB), .activeCount(cntB));

  function automatic int bitAt(int j);
    if (j < 0 || j >= NB) return 0;
    return bits[j];
  endfunction

  // Tap value after edge k (R4)
  function automatic int expTap(int k, int i);
    if ((i % 2) != ((k - 1) % 2)) return 0;
    if ((k - 3 - i) < 0) return 0;
    return bitAt((k - 3 - i) / 2);
  endfunction

  // Sliding window sum after edge k (R5)
  function automatic int expSum(int k, int n);
    int m = (k - 1) / 2;
    int s = 0;
    for (int j = m - n / 2; j < m; j++) s += bitAt(j);
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runStream(int mode);
    int prevA = 0;
    int prevB = 0;
    // mode 0: directed runs; mode 1: random
    for (int j = 0; j < NB; j++) begin
      if (mode == 0) begin
        if (j < 24)      bits[j] = 1;
        else if (j < 48) bits[j] = j % 2;
        else if (j < 64) bits[j] = 0;
        else             bits[j] = (j % 4 == 0) ? 0 : 1;
      end else begin
        bits[j] = int'($urandom % 2);
      end
    end
    rst = 1'b1;
    bitStrobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset taps A", int'(tapA), 0);
    check("R7 reset count A", int'(cntA), 0);
    check("R7 reset taps B", int'(tapB), 0);
    rst = 1'b0;
    for (int k = 1; k <= 2 * NB + 4; k++) begin
      bitStrobe = (k % 2) == 1;
      if ((k % 2) == 1) serIn = 1'(bitAt((k - 1) / 2));
      else if (mode == 0) serIn = 1'(1 - bitAt((k - 2) / 2)); // R1: contradicting junk
      else serIn = 1'($urandom % 2);
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < TAPS_A; i++) check("R4 tap A", int'(tapA[i]), expTap(k, i));
      for (int i = 0; i < TAPS_B; i++) check("R4 tap B", int'(tapB[i]), expTap(k, i));
      // R2 and R3: the group that is not driven on this edge must be zero
      for (int i = 0; i < TAPS_A; i++)
        if ((i % 2) != ((k - 1) % 2)) check("R2 R3 idle group A", int'(tapA[i]), 0);
      check("R5 R1 sum A", int'(cntA), expSum(k, TAPS_A));
      check("R5 R1 sum B", int'(cntB), expSum(k, TAPS_B));
      check("R6 step A", ((int'(cntA) - prevA) > 1 || (prevA - int'(cntA)) > 1) ? 1 : 0, 0);
      check("R6 step B", ((int'(cntB) - prevB) > 1 || (prevB - int'(cntB)) > 1) ? 1 : 0, 0);
      prevA = int'(cntA);
      prevB = int'(cntB);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    runStream(0);
    runStream(1);  // begins with a reset in the middle of a live stream (R7)
    runStream(1);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule